// File: doc/BRIEF.md
# Timed coin input limiter

This block conditions four coin-switch inputs for a CPU that polls them through a small register window. Each switch is brought into the clock domain through a two-stage synchronizer. A per-slot timer then reports a closed switch as an inserted coin for a bounded number of clock cycles only. A jammed or held switch therefore stops reading as a coin once that span has passed. The timer re-arms only when the switch opens again, so the next press gets a full new span.

The coin register is active low. The first read of it after reset returns all zeros, which tells boot firmware to skip its memory self-test. A second register holds controller-type codes for two expansion ports. Reads and writes use a simple single-cycle strobe. Read data is registered and appears in the cycle after the strobe.

Top module: `coin_window_ctl`

## Requirements
- R1: The coin register (offset 0x280) holds one bit per slot in bits [3:0], slot 0 in bit 0. A bit reads 0 while that slot is reported as inserted and 1 otherwise. Bits [7:4] always read 0.
- R2: The first read of offset 0x280 after reset returns 0x00 whatever the inputs are. Every later coin read returns live status. Reads of other offsets do not use up this one-shot.
- R3: Suppose a slot input is idle and is first sampled high at rising edge k. The first read that shows the slot as inserted is the read strobed at edge k+3, which allows two synchronizer stages and the timer.
- R4: While an input stays high, its bit reads 0 for exactly WINDOW_CYCLES consecutive read edges. After that it reads 1 for as long as the input stays high.
- R5: When an input goes low, the slot's timer clears and the report ends, counting the same three-edge latency as R3. The next press starts a new full window.
- R6: Each slot is timed independently of the other slots.
- R7: A write to offset 0x284 stores only data bits [7:4]. A read of 0x284 returns the stored bits, with bits [3:0] reading 0. Bits [5:4] give the type code of port A and bits [7:6] the type code of port B: 0 means a standard pad, 1 a light gun, and 2 or 3 a trackball. The reset value is 0x00.
- R8: Only address bits [10:0] are decoded. Offset 0x288 reads 0x00 and every other offset reads 0xFF. Writes to any offset other than 0x284 change nothing.
- R9: rdata_o updates on a rising edge where rd_i is high and holds its value otherwise. It resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coin_i | input | NUM_SLOTS | Raw coin switches, 1 = closed, may be asynchronous |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | ADDR_W | Register address; only bits [10:0] are decoded |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |

## Verification
The checks assume that rd_i and wr_i are synchronous to clk_i and that addr_i and wdata_i are stable while a strobe is high. The coin inputs may change at any time, because they pass through the synchronizer first. The window bound assumes WINDOW_CYCLES is at least 2. The bench drives every input on the falling edge and shortens the window to twelve cycles so that many full windows fit in one run. Random switch toggles sometimes land inside a window and sometimes after it has expired, and reads use both aliased and unmapped addresses.

// File: rtl/coin_window_pkg.sv
`timescale 1ns/1ps
package coin_window_pkg;

    // Number of low address bits taken part in decoding
    localparam int OFF_W    = 11;
    // Register offsets inside the decoded window
    localparam int OFF_COIN = 'h280;
    localparam int OFF_DEV  = 'h284;
    localparam int OFF_PAD  = 'h288;
    // Lowest data bit kept by the device-type register
    localparam int DEV_LSB  = 4;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_OPEN  = 2'd1,
        SLOT_SPENT = 2'd2
    } slot_state_e;

endpackage

// File: rtl/coin_sync.sv
`timescale 1ns/1ps
module coin_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.stage2;

endmodule

// File: rtl/coin_slot_timer.sv
`timescale 1ns/1ps
module coin_slot_timer
    import coin_window_pkg::*;
#(
    parameter int WINDOW_CYCLES = 20_000_000,
    localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic open_o
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WINDOW_CYCLES - 1);

    typedef struct packed {
        slot_state_e      state;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        case (tmr_q.state)
            SLOT_IDLE: begin
                if (level_i) begin
                    tmr_d.state = SLOT_OPEN;
                    tmr_d.cnt   = LOAD;
                end
            end
            SLOT_OPEN: begin
                if (!level_i) begin
                    tmr_d.state = SLOT_IDLE;
                    tmr_d.cnt   = '0;
                end else if (tmr_q.cnt == '0) begin
                    tmr_d.state = SLOT_SPENT;
                end else begin
                    tmr_d.cnt = tmr_q.cnt - 1'b1;
                end
            end
            SLOT_SPENT: begin
                if (!level_i) begin
                    tmr_d.state = SLOT_IDLE;
                end
            end
            default: begin
                tmr_d.state = SLOT_IDLE;
                tmr_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '{state: SLOT_IDLE, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign open_o = (tmr_q.state == SLOT_OPEN);

endmodule

// File: rtl/coin_reg_mux.sv
`timescale 1ns/1ps
module coin_reg_mux
    import coin_window_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [NUM_SLOTS-1:0] slot_open_i,
    output logic [DATA_W-1:0]    rdata_o
);

    localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);
    localparam logic [DATA_W-1:0] DEV_MASK  = {DATA_W{1'b1}} << DEV_LSB;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] dev;
        logic              first_done;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [ADDR_W-1:0] off;
    logic              hit_coin, hit_dev, hit_pad;
    logic [DATA_W-1:0] coin_word;

    always_comb begin
        off      = addr_i & ADDR_MASK;
        hit_coin = (off == ADDR_W'(OFF_COIN));
        hit_dev  = (off == ADDR_W'(OFF_DEV));
        hit_pad  = (off == ADDR_W'(OFF_PAD));
    end

    always_comb begin
        coin_word                 = '0;
        coin_word[NUM_SLOTS-1:0]  = ~slot_open_i;
    end

    always_comb begin
        regs_d = regs_q;
        if (rd_i) begin
            if (hit_coin) begin
                regs_d.rdata      = regs_q.first_done ? coin_word : '0;
                regs_d.first_done = 1'b1;
            end else if (hit_dev) begin
                regs_d.rdata = regs_q.dev;
            end else if (hit_pad) begin
                regs_d.rdata = '0;
            end else begin
                regs_d.rdata = '1;
            end
        end
        if (wr_i && hit_dev) begin
            regs_d.dev = wdata_i & DEV_MASK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o = regs_q.rdata;

endmodule

// File: rtl/coin_window_ctl.sv
`timescale 1ns/1ps
module coin_window_ctl
    import coin_window_pkg::*;
#(
    parameter int NUM_SLOTS     = 4,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int WINDOW_CYCLES = 20_000_000
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_SLOTS-1:0] coin_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o
);

    logic [NUM_SLOTS-1:0] coin_sync;
    logic [NUM_SLOTS-1:0] slot_open;

    coin_sync #(
        .WIDTH(NUM_SLOTS)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(coin_i),
        .sync_o (coin_sync)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        coin_slot_timer #(
            .WINDOW_CYCLES(WINDOW_CYCLES)
        ) tmr_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .level_i(coin_sync[s]),
            .open_o (slot_open[s])
        );
    end

    coin_reg_mux #(
        .NUM_SLOTS(NUM_SLOTS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) mux_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_i       (rd_i),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .slot_open_i(slot_open),
        .rdata_o    (rdata_o)
    );

endmodule

// File: rtl/coin_window_chk.sv
`timescale 1ns/1ps
module coin_window_chk
    import coin_window_pkg::*;
#(
    parameter int NUM_SLOTS     = 4,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int WINDOW_CYCLES = 20_000_000
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 rd_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [DATA_W-1:0]    rdata_o,
    input logic [NUM_SLOTS-1:0] coin_sync,
    input logic [NUM_SLOTS-1:0] slot_open
);

    localparam logic [ADDR_W-1:0] MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

    logic rd_coin, rd_dev, rd_pad, rd_other;
    assign rd_coin  = rd_i && ((addr_i & MASK) == ADDR_W'(OFF_COIN));
    assign rd_dev   = rd_i && ((addr_i & MASK) == ADDR_W'(OFF_DEV));
    assign rd_pad   = rd_i && ((addr_i & MASK) == ADDR_W'(OFF_PAD));
    assign rd_other = rd_i && !rd_coin && !rd_dev && !rd_pad;

    logic seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else if (rd_coin) seen_q <= 1'b1;
    end

    AST_COIN_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_coin |=> rdata_o[DATA_W-1:NUM_SLOTS] == '0); // R1

    AST_FIRST_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_coin && !seen_q) |=> rdata_o == '0); // R2

    AST_RELEASE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (coin_sync == '0) |=> (slot_open == '0)); // R5

    AST_DEV_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_dev |=> rdata_o[DEV_LSB-1:0] == '0); // R7

    AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_pad |=> rdata_o == '0); // R8

    AST_UNMAPPED_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_other |=> rdata_o == '1); // R8

    AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o)); // R9

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_win
        logic [31:0] run_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) run_q <= '0;
            else if (!slot_open[s]) run_q <= '0;
            else if (run_q != 32'hFFFF_FFFF) run_q <= run_q + 1'b1;
        end

        AST_WINDOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
            slot_open[s] |-> (run_q < 32'(WINDOW_CYCLES))); // R4
    end

endmodule

bind coin_window_ctl coin_window_chk #(
    .NUM_SLOTS    (NUM_SLOTS),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .WINDOW_CYCLES(WINDOW_CYCLES)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .rdata_o  (rdata_o),
    .coin_sync(coin_sync),
    .slot_open(slot_open)
);

// File: tb/coin_window_ctl_tb_top.sv
`timescale 1ns/1ps
module coin_window_ctl_tb_top;

    localparam int W  = 12;
    localparam int NS = 4;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] coin  = '0;
    logic          rd    = 1'b0;
    logic          wr    = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;

    always #2.5 clk = ~clk;

    coin_window_ctl #(
        .NUM_SLOTS(NS), .ADDR_W(AW), .DATA_W(DW), .WINDOW_CYCLES(W)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .coin_i(coin), .rd_i(rd), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model: run length of each input sampled high, three edges deep
    int            r1 [NS];
    int            r2 [NS];
    int            r3 [NS];
    bit            first_m;
    logic [DW-1:0] dev_m;
    logic [DW-1:0] exp_q;

    function automatic logic [AW-1:0] offs(input logic [AW-1:0] a);
        return a & 16'h07FF;
    endfunction

    function automatic logic [DW-1:0] coin_exp();
        logic [DW-1:0] v = '0;
        for (int s = 0; s < NS; s++) v[s] = !(r3[s] >= 1 && r3[s] <= W);
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) begin r1[s] = 0; r2[s] = 0; r3[s] = 0; end
            first_m = 1'b0;
            dev_m   = '0;
            exp_q   = '0;
        end else begin
            if (rd) begin
                case (offs(addr))
                    16'h0280: begin exp_q = first_m ? coin_exp() : '0; first_m = 1'b1; end
                    16'h0284: exp_q = dev_m;
                    16'h0288: exp_q = '0;
                    default:  exp_q = 8'hFF;
                endcase
            end
            if (wr && offs(addr) == 16'h0284) dev_m = wdata & 8'hF0;
            for (int s = 0; s < NS; s++) begin
                int nr;
                nr = coin[s] ? ((r1[s] < 1000) ? r1[s] + 1 : r1[s]) : 0;
                r3[s] = r2[s];
                r2[s] = r1[s];
                r1[s] = nr;
            end
        end
    end

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic do_read(input logic [AW-1:0] a, input string tag);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        check(tag, rdata, exp_q);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic hold_count(input int slot, input string tag, output int lows, output int first_low);
        lows = 0; first_low = -1;
        coin[slot] = 1'b1;
        for (int i = 0; i < W + 8; i++) begin
            do_read(16'h0280, tag);
            if (!rdata[slot]) begin
                lows++;
                if (first_low < 0) first_low = i;
            end
        end
    endtask

    initial begin
        int lows;
        int fl;
        void'($urandom(32'h5EED_C01E));
        do_reset();
        check("R9 reset value", rdata, 8'h00);

        // One-shot first read, then live idle status
        do_read(16'h0284, "R2 dev read before coin");
        do_read(16'h0280, "R2 first coin read");
        check("R2 first read literal", rdata, 8'h00);
        do_read(16'h0280, "R1 idle coin read");
        check("R1 idle literal", rdata, 8'h0F);

        // Hold slot 0: latency and window length
        hold_count(0, "R3/R4 hold slot0", lows, fl);
        check("R4 window length", DW'(lows), DW'(W));
        check("R3 first report edge", DW'(fl), 8'd3);
        check("R1 high nibble", rdata & 8'hF0, 8'h00);
        // Slot 1 while slot 0 is still held and spent
        hold_count(1, "R6 slot1 while slot0 spent", lows, fl);
        check("R6 independent window", DW'(lows), DW'(W));
        check("R4 spent reads high", rdata & 8'h03, 8'h03);

        // Release and press again: new full window
        coin[0] = 1'b0;
        idle(4);
        hold_count(0, "R5 re-press", lows, fl);
        check("R5 re-armed window", DW'(lows), DW'(W));

        // Release in the middle of a window
        coin = '0;
        idle(4);
        coin[2] = 1'b1;
        repeat (5) do_read(16'h0280, "R5 mid press");
        coin[2] = 1'b0;
        repeat (5) do_read(16'h0280, "R5 mid release");
        check("R5 released literal", rdata, 8'h0F);

        // Device-type register and decode
        do_write(16'h0284, 8'hA7);
        do_read(16'h0284, "R7 dev readback");
        check("R7 dev literal", rdata, 8'hA0);
        do_write(16'h0280, 8'h55);
        do_write(16'h0288, 8'h33);
        do_read(16'h0284, "R8 stray writes ignored");
        check("R8 dev unchanged", rdata, 8'hA0);
        do_read(16'hF288, "R8 pad alias");
        check("R8 pad literal", rdata, 8'h00);
        do_read(16'h028C, "R8 unmapped");
        check("R8 unmapped literal", rdata, 8'hFF);
        do_read(16'h0A80, "R8 coin alias");
        idle(3);
        check("R9 hold without strobe", rdata, exp_q);

        // Reset in mid run re-arms the one-shot and clears the device type
        coin = 4'b1010;
        do_reset();
        check("R9 reset clears data", rdata, 8'h00);
        do_read(16'h0284, "R7 dev reset value");
        check("R7 dev reset literal", rdata, 8'h00);
        idle(4);
        do_read(16'h0280, "R2 first read after second reset");
        check("R2 re-armed literal", rdata, 8'h00);

        // Random phase
        for (int it = 0; it < 4000; it++) begin
            logic [AW-1:0] a;
            int sel;
            if ($urandom_range(7) == 0) coin[$urandom_range(NS - 1)] ^= 1'b1;
            sel = $urandom_range(5);
            case (sel)
                0, 1: a = 16'h0280;
                2:    a = 16'h0280 | (16'($urandom_range(31)) << 11);
                3:    a = 16'h0284;
                4:    a = 16'h0288;
                default: a = 16'($urandom());
            endcase
            rd    = ($urandom_range(1) == 1);
            wr    = ($urandom_range(9) == 0);
            addr  = a;
            wdata = 8'($urandom());
            @(negedge clk);
            rd = 1'b0; wr = 1'b0;
            check("R4/R5/R6/R8/R9 random", rdata, exp_q);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule